// File: doc/BRIEF.md
# Memory-to-Stream Read Data Mover

The block reads a byte region from a memory-mapped AXI4 slave and delivers it as a packed AXI4-Stream. Each request arrives on a command stream. A request carries a start byte address and a byte count. The block reads the word-aligned span that covers the region. It splits that span into INCR bursts that never cross a 4 KB line. Up to a fixed number of bursts can wait for data at once.

Read data has no byte strobe, so the block works out the valid bytes of each returned word itself. It uses the command's start offset and end position to do this. It then shifts the bytes down into a two-word accumulator. From there it sends full stream beats, plus one final partial beat that carries TKEEP and TLAST.

When every byte of a command has left the stream port, one status beat reports the result. The next command is taken only after that status beat has been accepted. Backpressure on the stream output stalls acceptance of read data, so no byte is ever dropped.

Top module: `mm2s_mover`

## Requirements
- R1: After reset, cmd_ready is 1 and ar_valid, m_valid and sts_valid are 0. A command is accepted only while no earlier command is still in progress. Acceptance resumes only after the earlier command's status beat has been taken.
- R2: No read burst crosses a 4 KB address line: ar_addr[11:0] + (ar_len+1)*NB <= 4096, where NB = DATA_W/8.
- R3: Each burst has min(MAX_BURST, words still to request, words left before the next 4 KB line) beats, so ar_len is always below MAX_BURST.
- R4: The first burst starts at the start address with its low log2(NB) bits cleared. Later bursts follow on contiguously. Together they request ceil((addr mod NB + len)/NB) words in total. Every burst uses ar_size = log2(NB) and ar_burst = 2'b01 (INCR). A burst's address and length stay stable while it waits for ar_ready.
- R5: No more than MAX_OUT bursts (6 by default) are issued whose last data beat has not yet returned.
- R6: Stream byte k of a command, counted from byte lane 0 of the first beat, equals the memory byte at address addr+k, for k from 0 to len-1.
- R7: m_keep is all ones on every beat except the final one. On the final beat it has its low ((len-1) mod NB)+1 bits set and the rest clear.
- R8: m_last is 1 on the beat that carries byte len-1 of the command and on no other beat.
- R9: While m_valid is 1 and m_ready is 0, m_data, m_keep and m_last hold their values. Any pattern of m_ready stalls leaves the delivered byte sequence unchanged.
- R10: Each command produces exactly one status beat. If every read beat answered OKAY (2'b00), sts_ok is 1 and sts_resp is 2'b00. Otherwise sts_ok is 0 and sts_resp is the first non-OKAY code returned in address order. The status beat holds its value while it waits for sts_ready.
- R11: A command with a byte count of zero issues no read and produces no stream beat. It still returns one status beat with sts_ok = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_len | input | LEN_W | Byte count |
| ar_valid | output | 1 | Read address valid |
| ar_ready | input | 1 | Read address accepted |
| ar_addr | output | ADDR_W | Burst start address, word aligned |
| ar_len | output | 8 | Beats in burst minus one |
| ar_size | output | 3 | log2 of bytes per beat |
| ar_burst | output | 2 | Burst type, always INCR |
| r_valid | input | 1 | Read data valid |
| r_ready | output | 1 | Read data accepted |
| r_data | input | DATA_W | Read data word |
| r_resp | input | 2 | Read response code |
| r_last | input | 1 | Final beat of a burst |
| m_valid | output | 1 | Stream beat valid |
| m_ready | input | 1 | Stream sink ready |
| m_data | output | DATA_W | Packed stream data |
| m_keep | output | DATA_W/8 | Valid byte lanes |
| m_last | output | 1 | Final beat of the command |
| sts_valid | output | 1 | Status beat valid |
| sts_ready | input | 1 | Status beat accepted |
| sts_ok | output | 1 | All read beats answered OKAY |
| sts_resp | output | 2 | First non-OKAY response, else 0 |

## Verification
The bench builds the block with 32-bit data, a 12-bit length field, 16-beat bursts and six outstanding bursts. At these sizes it can sweep every start offset against a dense range of short lengths, so every combination of first-word and last-word trimming is covered. Start addresses just below a 4 KB line, together with requests of several hundred bytes, exercise the first-burst shortening, the splitting at the maximum burst length and the cap on outstanding bursts. Random stalls on the address, data, stream and status handshakes are switched on for part of the sweep, and reads that return error codes check which code the status reports.

// File: rtl/mm2s_mover.sv
module mm2s_mover #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int MAX_BURST = 16,
  parameter int MAX_OUT   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  output logic              ar_valid,
  input  logic              ar_ready,
  output logic [ADDR_W-1:0] ar_addr,
  output logic [7:0]        ar_len,
  output logic [2:0]        ar_size,
  output logic [1:0]        ar_burst,
  input  logic              r_valid,
  output logic              r_ready,
  input  logic [DATA_W-1:0] r_data,
  input  logic [1:0]        r_resp,
  input  logic              r_last,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic [DATA_W/8-1:0] m_keep,
  output logic              m_last,
  output logic              sts_valid,
  input  logic              sts_ready,
  output logic              sts_ok,
  output logic [1:0]        sts_resp
);
  localparam int NB = DATA_W / 8;
  localparam int OB = $clog2(NB);
  localparam int CW = $clog2(2 * NB + 1);
  localparam int OW = $clog2(MAX_OUT + 1);

  typedef enum logic [1:0] {IDLE, RUN, DONE} st_t;
  st_t st;

  logic [ADDR_W-1:0]   iss_addr;
  logic [LEN_W:0]      iss_left, rx_left;
  logic [LEN_W-1:0]    out_left;
  logic [OB-1:0]       off, tail;
  logic                rx_first;
  logic [OW-1:0]       ost;
  logic [2*DATA_W-1:0] acc;
  logic [CW-1:0]       cnt;
  logic [1:0]          err_q;

  // command decode
  logic [31:0] span, words;
  assign span  = 32'(cmd_addr[OB-1:0]) + 32'(cmd_len);
  assign words = (cmd_len == '0) ? 32'd0 : (span + NB - 1) >> OB;
  assign cmd_ready = (st == IDLE);
  wire cmd_hs = cmd_valid && cmd_ready;

  // burst sizing
  logic [12:0] page_room, page_beats;
  logic [31:0] burst;
  assign page_room  = 13'h1000 - {1'b0, iss_addr[11:0]};
  assign page_beats = page_room >> OB;
  always_comb begin
    burst = 32'(MAX_BURST);
    if (32'(iss_left) < burst) burst = 32'(iss_left);
    if (32'(page_beats) < burst) burst = 32'(page_beats);
  end

  assign ar_valid = (st == RUN) && (iss_left != '0) && (32'(ost) < 32'(MAX_OUT));
  assign ar_addr  = iss_addr;
  assign ar_len   = burst[7:0] - 8'd1;
  assign ar_size  = 3'(OB);
  assign ar_burst = 2'b01;
  wire ar_hs = ar_valid && ar_ready;

  // output side of the accumulator
  logic [CW-1:0] e, pop_n, cnt_after;
  assign e       = (cnt >= CW'(NB)) ? CW'(NB) : cnt;
  assign m_valid = (st == RUN) && (cnt != '0) &&
                   ((cnt >= CW'(NB)) || (32'(cnt) == 32'(out_left)));
  assign m_last  = m_valid && (32'(e) == 32'(out_left));
  assign m_data  = acc[DATA_W-1:0];
  assign m_keep  = ~({NB{1'b1}} << e);
  assign pop_n     = (m_valid && m_ready) ? e : '0;
  assign cnt_after = cnt - pop_n;

  // input side: trim and realign each returned word
  logic [CW-1:0] lo, hi, nin;
  assign lo  = rx_first ? CW'(off) : '0;
  assign hi  = (rx_left == 1) ? CW'(tail) + CW'(1) : CW'(NB);
  assign nin = hi - lo;
  assign r_ready = (st == RUN) && (rx_left != '0) && (cnt_after <= CW'(NB));
  wire push = r_valid && r_ready;

  logic [2*DATA_W-1:0] ext, mask, acc_next;
  assign ext  = {{DATA_W{1'b0}}, r_data >> {lo, 3'b000}};
  assign mask = ~({2*DATA_W{1'b1}} << {nin, 3'b000});
  assign acc_next = (acc >> {pop_n, 3'b000}) |
                    (push ? ((ext & mask) << {cnt_after, 3'b000}) : '0);

  assign sts_valid = (st == DONE);
  assign sts_ok    = (err_q == 2'b00);
  assign sts_resp  = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; iss_addr <= '0; iss_left <= '0; rx_left <= '0; out_left <= '0;
      off <= '0; tail <= '0; rx_first <= 1'b0; ost <= '0; acc <= '0; cnt <= '0;
      err_q <= 2'b00;
    end else begin
      acc <= acc_next;
      cnt <= cnt_after + (push ? nin : '0);
      out_left <= out_left - LEN_W'(pop_n);
      ost <= ost + OW'(ar_hs) - OW'(push && r_last);
      if (ar_hs) begin
        iss_addr <= iss_addr + ADDR_W'(burst << OB);
        iss_left <= iss_left - (LEN_W+1)'(burst);
      end
      if (push) begin
        rx_left  <= rx_left - 1'b1;
        rx_first <= 1'b0;
        if (err_q == 2'b00 && r_resp != 2'b00) err_q <= r_resp;
      end
      case (st)
        IDLE: if (cmd_hs) begin
          st       <= RUN;
          off      <= cmd_addr[OB-1:0];
          tail     <= OB'(span - 32'd1);
          iss_addr <= {cmd_addr[ADDR_W-1:OB], {OB{1'b0}}};
          iss_left <= (LEN_W+1)'(words);
          rx_left  <= (LEN_W+1)'(words);
          out_left <= cmd_len;
          rx_first <= 1'b1;
          err_q    <= 2'b00;
        end
        RUN:  if (rx_left == '0 && out_left == '0) st <= DONE;
        DONE: if (sts_ready) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !ar_valid && !m_valid && !sts_valid);
  assert_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid |-> (32'(ar_addr[11:0]) + ((32'(ar_len) + 32'd1) << OB)) <= 32'h1000);
  assert_burst_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid |-> 32'(ar_len) < 32'(MAX_BURST));
  assert_ar_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid && !ar_ready |=> ar_valid && $stable(ar_addr) && $stable(ar_len));
  assert_ar_attr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid |-> ar_size == 3'(OB) && ar_burst == 2'b01);
  assert_outstanding_R5: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ost) <= 32'(MAX_OUT));
  assert_keep_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_last |-> m_keep == {NB{1'b1}});
  assert_stream_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_keep) && $stable(m_last));
  assert_sts_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sts_valid && !sts_ready |=> sts_valid && $stable(sts_resp));
endmodule

// File: tb/mm2s_mover_test.sv
module mm2s_mover_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic cmd_valid = 0, cmd_ready;
  logic [31:0] cmd_addr = 0;
  logic [11:0] cmd_len = 0;
  logic ar_valid, ar_ready = 0;
  logic [31:0] ar_addr;
  logic [7:0] ar_len;
  logic [2:0] ar_size;
  logic [1:0] ar_burst;
  logic r_valid = 0, r_ready, r_last = 0;
  logic [31:0] r_data = 0;
  logic [1:0] r_resp = 0;
  logic m_valid, m_ready = 0, m_last;
  logic [31:0] m_data;
  logic [3:0] m_keep;
  logic sts_valid, sts_ready = 0, sts_ok;
  logic [1:0] sts_resp;

  mm2s_mover #(.DATA_W(32), .ADDR_W(32), .LEN_W(12), .MAX_BURST(16), .MAX_OUT(6)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .ar_valid(ar_valid), .ar_ready(ar_ready),
    .ar_addr(ar_addr), .ar_len(ar_len), .ar_size(ar_size), .ar_burst(ar_burst),
    .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data), .r_resp(r_resp), .r_last(r_last),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_keep(m_keep), .m_last(m_last),
    .sts_valid(sts_valid), .sts_ready(sts_ready), .sts_ok(sts_ok), .sts_resp(sts_resp));

  int n_chk = 0, n_fail = 0;
  bit stall = 0, hold_r = 0, err_on = 0;
  logic [31:0] err_w1 = 0, err_w2 = 0;

  logic [31:0] q_addr [8];
  int q_len [8];
  int qh = 0, qt = 0, qn = 0, beat = 0;

  int cur_len = 0, exp_words_left = 0, ar_cnt = 0, ar_bad = 0;
  logic [31:0] exp_next_ar = 0;
  logic [7:0] got [4096];
  int got_n = 0, keep_bad = 0, last_bad = 0, last_cnt = 0;
  int sts_cnt = 0;
  logic cap_ok;
  logic [1:0] cap_resp;

  function automatic logic [7:0] mb(input logic [31:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5a;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // port-level model of the memory slave and the stream/status sinks
  always @(negedge clk) begin
    logic [31:0] wa;
    ar_ready = (qn < 8) && (!stall || ($urandom % 2 == 0));
    if (qn != 0 && !hold_r && (!stall || ($urandom % 4 != 0))) begin
      wa = q_addr[qh] + 32'(beat * 4);
      r_valid = 1;
      for (int j = 0; j < 4; j++) r_data[8*j +: 8] = mb(wa + 32'(j));
      r_last = (beat == q_len[qh] - 1);
      r_resp = (err_on && wa == err_w1) ? 2'd2 : (err_on && wa == err_w2) ? 2'd3 : 2'd0;
    end else begin
      r_valid = 0; r_data = 0; r_last = 0; r_resp = 0;
    end
    m_ready   = !stall || ($urandom % 2 == 0);
    sts_ready = !stall || ($urandom % 2 == 0);
    #1;
    if (ar_valid && ar_ready) begin
      int room, e;
      room = (4096 - int'(ar_addr[11:0])) / 4;
      e = 16;
      if (exp_words_left < e) e = exp_words_left;
      if (room < e) e = room;
      if (ar_addr != exp_next_ar || int'(ar_len) + 1 != e || ar_size != 3'd2 || ar_burst != 2'b01)
        ar_bad++;
      exp_next_ar = exp_next_ar + 32'(e * 4);
      exp_words_left -= e;
      ar_cnt++;
      q_addr[qt] = ar_addr; q_len[qt] = int'(ar_len) + 1;
      qt = (qt + 1) % 8; qn++;
    end
    if (r_valid && r_ready) begin
      beat++;
      if (beat == q_len[qh]) begin beat = 0; qh = (qh + 1) % 8; qn--; end
    end
    if (m_valid && m_ready) begin
      int nb;
      nb = (cur_len - got_n < 4) ? cur_len - got_n : 4;
      if (nb < 1) nb = 1;
      if (m_keep != 4'((1 << nb) - 1)) keep_bad++;
      if (m_last != (got_n + nb == cur_len)) last_bad++;
      if (m_last) last_cnt++;
      for (int j = 0; j < 4; j++)
        if (m_keep[j] && got_n < 4096) begin got[got_n] = m_data[8*j +: 8]; got_n++; end
    end
    if (sts_valid && sts_ready) begin
      sts_cnt++; cap_ok = sts_ok; cap_resp = sts_resp;
    end
  end

  task automatic run(input logic [31:0] addr, input int len, input logic [1:0] exp_resp);
    int s0, mism;
    logic [7:0] fg, fe;
    cur_len = len; got_n = 0; keep_bad = 0; last_bad = 0; last_cnt = 0;
    ar_cnt = 0; ar_bad = 0;
    exp_next_ar = addr & ~32'd3;
    exp_words_left = (len == 0) ? 0 : (int'(addr % 4) + len + 3) / 4;
    s0 = sts_cnt;
    @(negedge clk);
    cmd_addr = addr; cmd_len = 12'(len); cmd_valid = 1;
    forever begin #2; if (cmd_ready) break; @(negedge clk); end
    @(negedge clk);
    cmd_valid = 0;
    while (sts_cnt == s0) @(negedge clk);
    repeat (3) @(negedge clk);
    mism = 0; fg = 0; fe = 0;
    for (int k = 0; k < len && k < got_n; k++)
      if (got[k] != mb(addr + 32'(k))) begin
        if (mism == 0) begin fg = got[k]; fe = mb(addr + 32'(k)); end
        mism++;
      end
    chk(ar_bad == 0, "R2 R3 R4 burst plan", ar_bad, 0);
    chk(exp_words_left == 0, "R4 words requested", exp_words_left, 0);
    chk(got_n == len, "R6 byte count", got_n, len);
    chk(mism == 0, "R6 data byte", fg, fe);
    chk(keep_bad == 0, "R7 keep", keep_bad, 0);
    chk(last_bad == 0 && last_cnt == (len == 0 ? 0 : 1), "R8 last", last_cnt, len == 0 ? 0 : 1);
    chk(sts_cnt == s0 + 1, "R10 status count", sts_cnt - s0, 1);
    chk(cap_resp == exp_resp && cap_ok == (exp_resp == 0), "R10 status resp", cap_resp, exp_resp);
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    report();
  end

  initial begin
    repeat (4) @(negedge clk);
    #1;
    chk(cmd_ready && !ar_valid && !m_valid && !sts_valid, "R1 reset state",
        {cmd_ready, ar_valid, m_valid, sts_valid}, 4'b1000);
    rst_n = 1;
    // R6 R7 R8: every offset against short lengths
    for (int o = 0; o < 4; o++)
      for (int l = 1; l <= 24; l++) begin
        stall = (l % 3 == 0);   // R9: stalls must not lose or reorder bytes
        run(32'h100 + 32'(o), l, 2'd0);
      end
    // R2 R3: starts just below a 4 KB line
    for (int o = 0; o < 4; o++)
      for (int l = 1; l <= 90; l += 11) begin
        stall = (o % 2 == 1);
        run(32'h2FF4 + 32'(o), l, 2'd0);
        run(32'h3FC0 + 32'(o), l + 60, 2'd0);
      end
    stall = 1;
    run(32'h5F03, 700, 2'd0);
    stall = 0;
    // R11 zero length
    run(32'h700, 0, 2'd0);
    chk(ar_cnt == 0, "R11 no read", ar_cnt, 0);
    run(32'h703, 0, 2'd0);
    chk(ar_cnt == 0 && got_n == 0, "R11 no read offset", ar_cnt + got_n, 0);
    // R5 outstanding cap and R1 no acceptance while busy
    hold_r = 1;
    fork
      run(32'h8000, 512, 2'd0);
      begin
        repeat (40) @(negedge clk);
        #2;
        chk(ar_cnt == 6, "R5 outstanding", ar_cnt, 6);
        chk(cmd_ready == 0, "R1 busy", cmd_ready, 0);
        hold_r = 0;
      end
    join
    // R10 first error wins
    err_on = 1; err_w1 = 32'h9008; err_w2 = 32'h9014;
    run(32'h9001, 40, 2'd2);
    err_w1 = 32'h9FF0;
    run(32'h9002, 40, 2'd3);
    stall = 1;
    err_w1 = 32'h9010; err_w2 = 32'h9004;
    run(32'h9000, 30, 2'd3);
    err_on = 0; stall = 0;
    run(32'hA001, 7, 2'd0);
    report();
  end
endmodule